// File: doc/BRIEF.md
# Proximity Credential Length and Field Decoder

This block takes a demodulated proximity credential that arrives as three words: a 20-bit upper word, a 32-bit middle word and a 32-bit lower word. It works out how many bits the credential format holds. To do this it finds the highest set bit, which acts as a sentinel. A chain of tests in fixed priority picks which word holds the sentinel, and each test adds its own base offset. For the two common formats, 26 and 35 bits long, it also pulls out the facility code and the card number.

A one-cycle start strobe captures the three words. A right-shift counter then walks the chosen word one bit per clock until the word is empty. After that the block raises a one-cycle done pulse. The length, facility code, card number and a decoded flag are presented with that pulse, and they hold their values until the next completion.

Top module: `prox_format_decoder`

## Requirements
- R1: While rst_n is low and after it is released, done, bitlen, fc, cardnum and decoded are all zero until the first decode completes.
- R2: If hi2[15:0] is nonzero, bitlen is 63 plus the number of significant bits of hi2[19:0]. The bits hi2[19:16] alone do not select this case.
- R3: Otherwise, if hi[31:6] is nonzero, bitlen is 31 plus the number of significant bits of hi.
- R4: Otherwise, if hi[5] is 0, bitlen is exactly 37.
- R5: Otherwise, if hi[4:0] is nonzero, bitlen is 31 plus the number of significant bits of hi[4:0].
- R6: Otherwise, bitlen is the number of significant bits of lo. It is 0 when lo is zero.
- R7: When bitlen is 26, decoded is 1, cardnum is lo[16:1] and fc is lo[24:17], both zero-extended.
- R8: When bitlen is 35, decoded is 1, cardnum is lo[20:1] and fc is {hi[0], lo[31:21]}.
- R9: For any other bitlen, decoded, fc and cardnum are 0.
- R10: done is high for exactly one cycle. It rises N+1 clock edges after the edge that accepts start, where N is the number of significant bits of the word being shifted (N is 0 in the R4 case).
- R11: bitlen, fc, cardnum and decoded change only in the cycle where done is high.
- R12: A start that arrives while a decode is in progress is ignored, together with its data. Changes to hi2, hi or lo after the accepting edge also have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode when idle |
| hi2 | input | 20 | Upper credential word |
| hi | input | 32 | Middle credential word |
| lo | input | 32 | Lower credential word |
| done | output | 1 | One-cycle completion pulse |
| bitlen | output | 8 | Inferred format length |
| fc | output | 12 | Facility code |
| cardnum | output | 20 | Card number |
| decoded | output | 1 | Fields valid for a known format |

## Verification
The assertions assume that start is a synchronous input. They also assume that a start seen during a decode changes nothing except that the shift keeps going. That is why they tie the count increment, and not the output, to such a start. The stimulus drives start and the three words only on falling edges. It deliberately pulses start and changes the words while a decode is in progress, and it sometimes holds start high across a completion. The words are chosen so that every branch of the cascade is reached, including an upper word whose only set bits lie above bit 15.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int HI2_W  = 20;
  localparam int KEY_W  = 16;
  localparam int WORD_W = 32;
  localparam int SEED_W = (HI2_W > WORD_W) ? HI2_W : WORD_W;
  localparam int LEN_W  = 8;
  localparam int FC_W   = 12;
  localparam int CN_W   = 20;
  localparam int TAIL_W = 5;

  localparam logic [LEN_W-1:0] BASE_WIDE = LEN_W'(63);
  localparam logic [LEN_W-1:0] BASE_MID  = LEN_W'(31);
  localparam logic [LEN_W-1:0] LEN_FIXED = LEN_W'(37);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(26);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(35);

  typedef enum logic [2:0] {BR_WIDE, BR_MID, BR_FIXED, BR_TAIL, BR_LOW} branch_e;

  // Priority cascade: earlier tests win.
  function automatic branch_e pick_branch(input logic [HI2_W-1:0] h2,
                                          input logic [WORD_W-1:0] h);
    if (h2[KEY_W-1:0] != '0)             return BR_WIDE;
    if (h[WORD_W-1:TAIL_W+1] != '0)      return BR_MID;
    if (!h[TAIL_W])                      return BR_FIXED;
    if (h[TAIL_W-1:0] != '0)             return BR_TAIL;
    return BR_LOW;
  endfunction

  function automatic logic [LEN_W-1:0] base_of(input branch_e b);
    case (b)
      BR_WIDE:  return BASE_WIDE;
      BR_MID:   return BASE_MID;
      BR_FIXED: return LEN_FIXED;
      BR_TAIL:  return BASE_MID;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [SEED_W-1:0] seed_of(input branch_e b,
                                                input logic [HI2_W-1:0] h2,
                                                input logic [WORD_W-1:0] h,
                                                input logic [WORD_W-1:0] l);
    case (b)
      BR_WIDE:  return SEED_W'(h2);
      BR_MID:   return SEED_W'(h);
      BR_FIXED: return '0;
      BR_TAIL:  return SEED_W'(h[TAIL_W-1:0]);
      default:  return SEED_W'(l);
    endcase
  endfunction
endpackage

// File: rtl/pfd_len_select.sv
module pfd_len_select
  import pfd_pkg::*;
(
  input  logic [HI2_W-1:0]  hi2,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  output branch_e           branch,
  output logic [LEN_W-1:0]  base,
  output logic [SEED_W-1:0] seed
);
  always_comb begin
    branch = pick_branch(hi2, hi);
    base   = base_of(branch);
    seed   = seed_of(branch, hi2, hi, lo);
  end
endmodule

// File: rtl/pfd_shift_count.sv
module pfd_shift_count
  import pfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEED_W-1:0] seed,
  input  logic [LEN_W-1:0]  base,
  output logic              accept,
  output logic              busy,
  output logic              finish,
  output logic [LEN_W-1:0]  count
);
  logic [SEED_W-1:0] val;

  assign accept = start && !busy;
  assign finish = busy && (val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      val   <= '0;
      count <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        val   <= seed;
        count <= base;
      end
    end else if (val != '0) begin
      val   <= val >> 1;
      count <= count + 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  // R12: a start during a busy shift only lets the count advance
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (val != '0) |=> busy && (count == $past(count) + 1'b1));

  // R10: completion always returns the counter to idle
  a_r10_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
endmodule

// File: rtl/pfd_field_extract.sv
module pfd_field_extract
  import pfd_pkg::*;
(
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  output logic [FC_W-1:0]   fc,
  output logic [CN_W-1:0]   cardnum,
  output logic              decoded
);
  always_comb begin
    fc      = '0;
    cardnum = '0;
    decoded = 1'b0;
    if (len == LEN_SHORT) begin
      cardnum = CN_W'(lo[16:1]);
      fc      = FC_W'(lo[24:17]);
      decoded = 1'b1;
    end else if (len == LEN_LONG) begin
      cardnum = lo[20:1];
      fc      = {hi[0], lo[31:21]};
      decoded = 1'b1;
    end
  end
endmodule

// File: rtl/prox_format_decoder.sv
module prox_format_decoder
  import pfd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [HI2_W-1:0]   hi2,
  input  logic [WORD_W-1:0]  hi,
  input  logic [WORD_W-1:0]  lo,
  output logic               done,
  output logic [LEN_W-1:0]   bitlen,
  output logic [FC_W-1:0]    fc,
  output logic [CN_W-1:0]    cardnum,
  output logic               decoded
);
  branch_e           branch;
  logic [LEN_W-1:0]  base;
  logic [SEED_W-1:0] seed;
  logic              accept, busy, finish;
  logic [LEN_W-1:0]  count;
  logic [WORD_W-1:0] hi_q, lo_q;
  logic [FC_W-1:0]   fc_n;
  logic [CN_W-1:0]   cn_n;
  logic              dec_n;

  pfd_len_select u_sel (
    .hi2(hi2), .hi(hi), .lo(lo),
    .branch(branch), .base(base), .seed(seed)
  );

  pfd_shift_count u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .base(base),
    .accept(accept), .busy(busy), .finish(finish), .count(count)
  );

  pfd_field_extract u_ext (
    .len(count), .hi(hi_q), .lo(lo_q),
    .fc(fc_n), .cardnum(cn_n), .decoded(dec_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (accept) begin
      hi_q <= hi;
      lo_q <= lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      bitlen  <= '0;
      fc      <= '0;
      cardnum <= '0;
      decoded <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        bitlen  <= count;
        fc      <= fc_n;
        cardnum <= cn_n;
        decoded <= dec_n;
      end
    end
  end

  // R10: done is a single-cycle pulse that follows the counter's finish
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done);

  // R4: the fixed-length branch finishes on the very next edge
  a_r4_fixed_fast: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (branch == BR_FIXED) |=> finish);

  // R11: results hold outside the done cycle
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({bitlen, fc, cardnum, decoded}));

  // R7: the 26-bit format yields narrow fields
  a_r7_short_fields: assert property (@(posedge clk) disable iff (!rst_n)
    done && (bitlen == LEN_SHORT) |-> decoded && (fc[FC_W-1:8] == '0) && (cardnum[CN_W-1:16] == '0));

  // R9: unknown lengths carry no fields
  a_r9_other_len: assert property (@(posedge clk) disable iff (!rst_n)
    done && (bitlen != LEN_SHORT) && (bitlen != LEN_LONG) |-> !decoded && (fc == '0) && (cardnum == '0));
endmodule

// File: tb/prox_format_decoder_test.sv
module prox_format_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] hi2 = '0;
  logic [31:0] hi = '0;
  logic [31:0] lo = '0;
  logic        done, decoded;
  logic [7:0]  bitlen;
  logic [11:0] fc;
  logic [19:0] cardnum;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  prox_format_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .hi2(hi2), .hi(hi), .lo(lo),
    .done(done), .bitlen(bitlen), .fc(fc), .cardnum(cardnum), .decoded(decoded)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nbits(input longint unsigned v);
    int n = 0;
    while (v != 0) begin
      v = v >> 1;
      n++;
    end
    return n;
  endfunction

  // Behavioural reference model
  bit    m_busy = 0, m_done = 0, m_dec = 0, m_ign = 0;
  int    m_rem = 0, m_len = 0, m_fc = 0, m_cn = 0;
  int    p_len = 0, p_fc = 0, p_cn = 0;
  bit    p_dec = 0;
  string p_tag = "", m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_len = 0; m_fc = 0; m_cn = 0; m_dec = 0; m_ign = 0;
      m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (start) m_ign = 1;
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_done = 1;
          m_len = p_len; m_fc = p_fc; m_cn = p_cn; m_dec = p_dec;
          m_tag = m_ign ? {"R12/", p_tag} : p_tag;
        end
      end else if (start) begin
        int w;
        m_busy = 1; m_ign = 0;
        if (hi2[15:0] != 0) begin w = nbits(hi2); p_len = 63 + w; p_tag = "R2"; end
        else if ((hi >> 6) != 0) begin w = nbits(hi); p_len = 31 + w; p_tag = "R3"; end
        else if (hi[5] == 1'b0) begin w = 0; p_len = 37; p_tag = "R4"; end
        else if (hi[4:0] != 0) begin w = nbits(hi[4:0]); p_len = 31 + w; p_tag = "R5"; end
        else begin w = nbits(lo); p_len = w; p_tag = "R6"; end
        m_rem = w + 1;
        if (p_len == 26) begin
          p_cn = int'((lo >> 1) & 32'hFFFF); p_fc = int'((lo >> 17) & 32'hFF); p_dec = 1;
          p_tag = {p_tag, "/R7"};
        end else if (p_len == 35) begin
          p_cn = int'((lo >> 1) & 32'hFFFFF); p_fc = int'({hi[0], lo[31:21]}); p_dec = 1;
          p_tag = {p_tag, "/R8"};
        end else begin
          p_cn = 0; p_fc = 0; p_dec = 0;
          p_tag = {p_tag, "/R9"};
        end
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (done !== m_done) begin
        errors++;
        $display("FAIL R10 done: actual %0b expected %0b at %0t", done, m_done, $time);
      end
      checks++;
      if (bitlen !== m_len[7:0] || fc !== m_fc[11:0] || cardnum !== m_cn[19:0] || decoded !== m_dec) begin
        errors++;
        $display("FAIL %s%s: actual len=%0d fc=%0d cn=%0d dec=%0b expected len=%0d fc=%0d cn=%0d dec=%0b",
                 m_done ? "" : "R11 ", m_tag, bitlen, fc, cardnum, decoded, m_len, m_fc, m_cn, m_dec);
      end
    end
  end

  task automatic finish_sim();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic decode(input logic [19:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    hi2 = a; hi = b; lo = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hi2 = ~a; hi = ~b; lo = ~c;   // R12: late data changes must not matter
    while (!m_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (done !== 1'b0 || bitlen !== 8'd0 || fc !== 12'd0 || cardnum !== 20'd0 || decoded !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual done=%0b len=%0d fc=%0d cn=%0d dec=%0b expected all zero",
               done, bitlen, fc, cardnum, decoded);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    decode(20'h0, 32'h20, 32'h0255_1235);        // R7: 26-bit format
    decode(20'h0, 32'h29, 32'h8765_4321);        // R8/R5: 35-bit format
    decode(20'h0, 32'h01, 32'hFFFF_FFFF);        // R4: fixed 37
    decode(20'h0, 32'h0000_1000, 32'h1);         // R3: 44
    decode(20'h0, 32'h8000_0000, 32'h0);         // R3: 63
    decode(20'h0_0001, 32'h0, 32'h0);            // R2: 64
    decode(20'hF_0001, 32'h0, 32'h0);            // R2: 83
    decode(20'hF_0000, 32'h25, 32'h0);           // R2 exclusion -> R5: 34
    decode(20'h0, 32'h20, 32'h0);                // R6: empty low word -> 0
    decode(20'h0, 32'h20, 32'h0000_0001);        // R6: 1
    decode(20'h0, 32'h2F, 32'h0000_0000);        // R5: 35 with hi[0]=1
    decode(20'h0, 32'h20, 32'h03FF_FFFF);        // R7: all-ones fields

    // R12: extra starts while busy are ignored
    @(negedge clk);
    hi2 = 20'h0; hi = 32'h4000_0000; lo = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    hi2 = 20'h0; hi = 32'h20; lo = 32'h0200_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);

    // R10/R12: start held high across completions
    @(negedge clk);
    hi2 = 20'h0; hi = 32'h20; lo = 32'h7; start = 1'b1;
    repeat (14) @(negedge clk);
    start = 1'b0;
    while (m_busy || m_done) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_sim();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end
endmodule